// File: doc/BRIEF.md
# Four-channel DMA request arbiter

This block decides which of four DMA channels is served next. For each channel it forms one request. That request is the hardware request line, brought to active-high by a programmable sense polarity and then gated by that channel's mask bit, ORed with a request bit that software sets. One winner is chosen, either by fixed order or by a rotating order. The arbiter then holds the grant on a one-hot acknowledge bus until the current service ends. The acknowledge bus also has a programmable polarity.

The surrounding controller reports the end of a service on `xfer_done`. It raises `xfer_tc` in the same cycle when the service reached terminal count. A channel marked as demand-mode also gives up its grant as soon as its request falls. A global disable input stops new grants but never takes away a grant already issued. The combined request vector is exported as the pending-request status.

Top module: `dma_arb`

## Requirements
- R1: With `cfg_rot`=0, a new grant goes to the lowest-numbered requesting channel (channel 0 highest, channel 3 lowest).
- R2: With `cfg_rot`=1, when the service of channel n ends, channel n+1 (mod 4) becomes highest priority and channel n lowest. After reset, channel 0 is highest.
- R3: `cfg_drq_hi`=1 treats a high `drq_in` bit as a request; `cfg_drq_hi`=0 treats a low bit as a request.
- R4: `dack_out` is one-hot on the granted channel when `grant_valid`=1 and all-inactive otherwise. Active level is high when `cfg_ack_hi`=1 and low when `cfg_ack_hi`=0.
- R5: While `cfg_off`=1 no new grant is issued. A grant already held stays held until its release condition.
- R6: A channel whose `chan_mask` bit is 1 is never granted and never shown pending on its hardware request alone.
- R7: A write (`swr_we`=1) sets or clears the software request of channel `swr_ch` to `swr_val`, and that request is granted whatever the mask. The software request of the granted channel clears when `xfer_done` and `xfer_tc` are both 1. A write to the same channel in that cycle wins.
- R8: `pending[i]` is 1 exactly when channel i has a masked hardware request or a software request, whether or not it is granted or disabled.
- R9: A grant is not pre-empted. It is released by `xfer_done`. In the cycle after the release edge `grant_valid` is 0, and re-arbitration takes place at the following edge.
- R10: If the granted channel's `chan_demand` bit is 1, the grant is also released at the first edge where that channel's request is absent. A non-demand channel keeps its grant when its request falls.
- R11: After reset `grant_valid` is 0, all software requests are clear and rotation starts from channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_off | input | 1 | Disable new grants |
| cfg_rot | input | 1 | 1 = rotating priority, 0 = fixed |
| cfg_drq_hi | input | 1 | Request line sense: 1 active high |
| cfg_ack_hi | input | 1 | Acknowledge output level: 1 active high |
| chan_mask | input | 4 | Per-channel hardware request mask |
| chan_demand | input | 4 | Per-channel demand-mode flag |
| drq_in | input | 4 | Raw hardware request lines |
| swr_we | input | 1 | Software request write strobe |
| swr_ch | input | 2 | Channel addressed by the write |
| swr_val | input | 1 | Value written to the software request |
| xfer_done | input | 1 | Current service finished |
| xfer_tc | input | 1 | Finished service reached terminal count |
| dack_out | output | 4 | One-hot acknowledge, programmable polarity |
| grant_valid | output | 1 | A channel is granted |
| grant_ch | output | 2 | Granted channel number |
| pending | output | 4 | Pending request status per channel |

## Verification
A software request write can land in the same cycle as the terminal-count clear of that same channel's software request. The bench provokes this by pulsing the write for the granted channel together with `xfer_done` and `xfer_tc`. It judges the result by seeing the channel still pending and granted a second time, then cleared once a later terminal count arrives with no write. Disable and a held grant also overlap: the disable is raised while a grant is active. The grant must stay on `dack_out` until `xfer_done`, and no new grant may follow while the disable remains.

// File: rtl/dma_arb.sv
module dma_arb #(
  parameter int NCH = 4,
  localparam int CW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_off,
  input  logic           cfg_rot,
  input  logic           cfg_drq_hi,
  input  logic           cfg_ack_hi,
  input  logic [NCH-1:0] chan_mask,
  input  logic [NCH-1:0] chan_demand,
  input  logic [NCH-1:0] drq_in,
  input  logic           swr_we,
  input  logic [CW-1:0]  swr_ch,
  input  logic           swr_val,
  input  logic           xfer_done,
  input  logic           xfer_tc,
  output logic [NCH-1:0] dack_out,
  output logic           grant_valid,
  output logic [CW-1:0]  grant_ch,
  output logic [NCH-1:0] pending
);

  logic           busy;
  logic [CW-1:0]  cur;
  logic [CW-1:0]  top;
  logic [NCH-1:0] sw_req;
  logic [NCH-1:0] sw_nxt;
  logic [NCH-1:0] hw_act;
  logic [NCH-1:0] req;
  logic [NCH-1:0] req_q;
  logic [CW-1:0]  win;
  logic           found;
  logic           release_now;
  logic [NCH-1:0] oh;

  assign hw_act  = cfg_drq_hi ? drq_in : ~drq_in;
  assign req     = (hw_act & ~chan_mask) | sw_req;
  assign pending = req;

  always_comb begin
    int base;
    base  = cfg_rot ? int'(top) : 0;
    found = 1'b0;
    win   = '0;
    for (int i = 0; i < NCH; i++) begin
      int j;
      j = base + i;
      if (j >= NCH) j = j - NCH;
      if (!found && req[j]) begin
        found = 1'b1;
        win   = CW'(j);
      end
    end
  end

  assign release_now = busy && (xfer_done || (chan_demand[cur] && !req[cur]));

  always_comb begin
    sw_nxt = sw_req;
    if (busy && xfer_done && xfer_tc) sw_nxt[cur] = 1'b0;
    if (swr_we) sw_nxt[swr_ch] = swr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cur    <= '0;
      top    <= '0;
      sw_req <= '0;
      req_q  <= '0;
    end else begin
      sw_req <= sw_nxt;
      req_q  <= req;
      if (release_now) begin
        busy <= 1'b0;
        if (cfg_rot) top <= (int'(cur) == NCH-1) ? '0 : cur + 1'b1;
      end else if (!busy && !cfg_off && found) begin
        busy <= 1'b1;
        cur  <= win;
      end
    end
  end

  assign oh          = busy ? (NCH'(1) << cur) : '0;
  assign dack_out    = cfg_ack_hi ? oh : ~oh;
  assign grant_valid = busy;
  assign grant_ch    = cur;

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !xfer_done && !(chan_demand[cur] && !req[cur]) |=> busy && $stable(cur));

  p_done_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && xfer_done |=> !busy);

  p_off_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && cfg_off |=> !busy);

  p_grant_had_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid && !$past(grant_valid) |-> req_q[grant_ch]);

  p_tc_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && xfer_done && xfer_tc && !(swr_we && swr_ch == cur) |=> !sw_req[cur]);

  p_demand_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && chan_demand[cur] && !req[cur] |=> !busy);

  p_ack_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cfg_ack_hi ? dack_out : ~dack_out));

endmodule

// File: tb/sim_dma_arb.sv
module sim_dma_arb;
  logic clk = 0, rst_n = 0;
  logic cfg_off = 0, cfg_rot = 0, cfg_drq_hi = 1, cfg_ack_hi = 0;
  logic [3:0] chan_mask = 0, chan_demand = 0, drq_in = 0;
  logic swr_we = 0, swr_val = 0, xfer_done = 0, xfer_tc = 0;
  logic [1:0] swr_ch = 0;
  logic [3:0] dack_out, pending;
  logic grant_valid;
  logic [1:0] grant_ch;

  always #5 clk = ~clk;

  dma_arb u0 (.clk(clk), .rst_n(rst_n), .cfg_off(cfg_off), .cfg_rot(cfg_rot),
    .cfg_drq_hi(cfg_drq_hi), .cfg_ack_hi(cfg_ack_hi), .chan_mask(chan_mask),
    .chan_demand(chan_demand), .drq_in(drq_in), .swr_we(swr_we), .swr_ch(swr_ch),
    .swr_val(swr_val), .xfer_done(xfer_done), .xfer_tc(xfer_tc), .dack_out(dack_out),
    .grant_valid(grant_valid), .grant_ch(grant_ch), .pending(pending));

  int total = 0, fails = 0, cyc = 0;
  int exp_q[$];
  string tag_q[$];
  logic gv_prev = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_dack(input int ch, input bit on);
    logic [3:0] oh;
    oh = on ? 4'(1 << ch) : 4'b0;
    return cfg_ack_hi ? oh : ~oh;
  endfunction

  always @(negedge clk) begin
    if (rst_n && grant_valid && !gv_prev) begin
      if (exp_q.size() == 0) begin
        chk(0, "R1 unexpected grant", grant_ch, -1);
      end else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(grant_ch == 2'(e), t, grant_ch, e);
        chk(dack_out == exp_dack(e, 1), "R4 dack on grant", dack_out, exp_dack(e, 1));
      end
    end
    gv_prev <= grant_valid;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      total++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic get_grant(input int ch, input string tag);
    exp_q.push_back(ch);
    tag_q.push_back(tag);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (grant_valid) return;
    end
    chk(0, {tag, " no grant"}, 0, ch);
  endtask

  task automatic hold(input int n, input int ch, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(grant_valid && grant_ch == 2'(ch), tag, grant_ch, ch);
    end
  endtask

  task automatic rel(input logic [3:0] after, input bit tc, input bit rewrite, input int ch);
    xfer_done = 1; xfer_tc = tc; drq_in = after;
    if (rewrite) begin swr_we = 1; swr_ch = 2'(ch); swr_val = 1; end
    @(negedge clk);
    xfer_done = 0; xfer_tc = 0; swr_we = 0;
    chk(!grant_valid, "R9 idle after release", grant_valid, 0);
  endtask

  task automatic serve(input int ch, input logic [3:0] after, input string tag);
    get_grant(ch, tag);
    hold(2, ch, "R9 grant held");
    rel(after, 0, 0, ch);
  endtask

  task automatic sw_write(input int ch, input bit v);
    swr_we = 1; swr_ch = 2'(ch); swr_val = v;
    @(negedge clk);
    swr_we = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!grant_valid, "R11 reset grant", grant_valid, 0);
    chk(dack_out == 4'hF, "R4 idle dack low-active", dack_out, 15);
    chk(pending == 0, "R11 reset pending", pending, 0);
    rst_n = 1;
    @(negedge clk);

    drq_in = 4'b1010;
    serve(1, 4'b1000, "R1 fixed picks 1");
    serve(3, 4'b0000, "R1 fixed picks 3");

    cfg_rot = 1; drq_in = 4'b1011;
    serve(0, 4'b1011, "R2 rotate 0");
    serve(1, 4'b1011, "R2 rotate 1");
    serve(3, 4'b1011, "R2 rotate 3");
    serve(0, 4'b0000, "R2 rotate wraps to 0");
    cfg_rot = 0;

    cfg_drq_hi = 0; drq_in = 4'b1011;
    @(negedge clk);
    chk(pending == 4'b0100, "R3 active-low pending", pending, 4);
    serve(2, 4'b1111, "R3 active-low grant");
    chk(pending == 0, "R8 none pending", pending, 0);
    cfg_drq_hi = 1; drq_in = 0;

    cfg_ack_hi = 1; drq_in = 4'b0100;
    serve(2, 4'b0000, "R4 high-active grant");
    chk(dack_out == 4'b0000, "R4 idle dack high-active", dack_out, 0);

    chan_mask = 4'b0001; drq_in = 4'b0011;
    @(negedge clk);
    chk(pending == 4'b0010, "R6 masked not pending", pending, 2);
    serve(1, 4'b0001, "R6 masked skipped");
    repeat (3) @(negedge clk);
    chk(!grant_valid, "R6 masked never granted", grant_valid, 0);
    chan_mask = 4'b1111; drq_in = 4'b1111;
    repeat (3) @(negedge clk);
    chk(!grant_valid && pending == 0, "R6 all masked", pending, 0);

    sw_write(3, 1);
    chk(pending == 4'b1000, "R7 sw pending", pending, 8);
    get_grant(3, "R7 sw grant under mask");
    rel(4'b1111, 1, 0, 3);
    chk(pending == 0, "R7 tc clears sw", pending, 0);
    sw_write(2, 1);
    get_grant(2, "R7 sw grant 2");
    rel(4'b1111, 1, 1, 2);
    chk(pending == 4'b0100, "R7 write wins over tc", pending, 4);
    get_grant(2, "R7 regrant after rewrite");
    rel(4'b1111, 1, 0, 2);
    chk(pending == 0, "R7 later tc clears", pending, 0);

    cfg_off = 1;
    sw_write(1, 1);
    repeat (4) @(negedge clk);
    chk(!grant_valid, "R5 disabled no grant", grant_valid, 0);
    chk(pending == 4'b0010, "R8 pending while disabled", pending, 2);
    sw_write(1, 0);
    chk(pending == 0, "R7 sw write clears", pending, 0);
    sw_write(1, 1);
    cfg_off = 0;
    get_grant(1, "R5 grant after enable");
    cfg_off = 1;
    hold(3, 1, "R5 held grant survives disable");
    rel(4'b1111, 1, 0, 1);
    cfg_off = 0;
    chk(pending == 0, "R7 cleared after disable test", pending, 0);

    chan_mask = 0; drq_in = 0; chan_demand = 4'b0001;
    @(negedge clk);
    drq_in = 4'b0001;
    get_grant(0, "R10 demand grant");
    drq_in = 0;
    @(negedge clk);
    chk(!grant_valid, "R10 demand drop releases", grant_valid, 0);
    chan_demand = 0; drq_in = 4'b0010;
    get_grant(1, "R10 non-demand grant");
    drq_in = 0;
    hold(3, 1, "R10 non-demand keeps grant");
    chk(dack_out == 4'b0010, "R4 dack during hold", dack_out, 2);
    rel(4'b0000, 0, 0, 1);

    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R1 all grants seen", exp_q.size(), 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule